// File: doc/BRIEF.md
# Sequenced Status Packet Generator

The block turns a parallel status word into a short byte-serial packet for an upstream status ring. When a packet is due, it raises a request line and offers a fixed address byte. Downstream accepts that byte by pulsing an acknowledge input. The block then latches the status word and drives the rest of the packet on consecutive clocks. The second byte joins a 6-bit sequence number (upper six bits) with status bits 1:0 (lower two bits). Each byte after that carries eight more status bits, starting at bit 2, until the payload width is used up.

A single 8-bit control write sets both the sequence number and the sending mode. Packets can be sent once on command, automatically whenever the status word changes, or both. Triggers that arrive while a request is already waiting are folded into that request. Triggers that arrive on the acceptance clock, or while a packet is being shifted out, are held and produce exactly one more packet when the current one ends.

Top module: `status_packet_gen`

## Requirements
- R1: After reset, pkt_req is low, pkt_byte is 0x00, the mode is 0 (idle) and the sequence number is 0.
- R2: Once raised, pkt_req stays high until a clock edge where pkt_ack is high, and it is low from the next cycle on.
- R3: While pkt_req is high, pkt_byte shows the address byte given by parameter ADDR_BYTE (default 0x3B).
- R4: In the cycle after acceptance, pkt_byte is {seq[5:0], status[1:0]}. Here status is the value present on the acceptance edge and seq is the sequence number held before that edge.
- R5: On the following consecutive cycles, pkt_byte carries status bits 9:2, then 17:10, then 25:18, up to ceil((PAYLOAD_W-2)/8) bytes, with unused upper bits zero. With PAYLOAD_W = 18 a packet is four bytes.
- R6: The payload is latched on the acceptance edge. A status change after that edge does not alter the packet in flight.
- R7: When no packet is being requested or shifted out, pkt_byte is 0x00.
- R8: A control write loads the sequence number from ctl_byte[7:2] and the mode from ctl_byte[1:0]. The modes are 0 = idle, 1 = send one packet, 2 = auto-send on status change, 3 = auto-send and send one now. When ctl_byte[0] is 1, pkt_req is high in the cycle after the write, if the block is idle. When ctl_byte[0] is 0, the write alone raises no request.
- R9: In modes 2 and 3, any status bit that differs from its value on the previous clock edge raises pkt_req in the next cycle. In modes 0 and 1, status changes have no effect.
- R10: Triggers that occur while pkt_req is high and pkt_ack is low add no extra packet.
- R11: A trigger on the acceptance edge, or while bytes are still being shifted out, produces exactly one more packet. Its request rises one idle cycle after the last payload byte, and pkt_req is never high while a packet is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_byte | input | 8 | Control value: [7:2] sequence number, [1:0] mode |
| status_in | input | PAYLOAD_W | Parallel status word |
| pkt_ack | input | 1 | Acceptance of the address byte |
| pkt_req | output | 1 | Request to send a packet |
| pkt_byte | output | 8 | Packet byte stream |

## Verification
Two events can coincide on the same edge: acceptance of a request, and a new trigger (a control write with the send bit set, or a status change in auto mode). The bench provokes this by pulsing pkt_ack together with a control write that changes both the sequence number and the mode. It judges the outcome in two steps. The packet in flight must still carry the old sequence number. A second request must then follow one idle cycle after the last payload byte, and that second packet must carry the new sequence number. The bench also confirms that no third packet appears.

// File: rtl/sts_pkg.sv
package sts_pkg;
   localparam int SEQ_W  = 6;
   localparam int BYTE_W = 8;

   // payload bytes after the sequence byte
   function automatic int pay_bytes(input int width);
      return (width - 2 + BYTE_W - 1) / BYTE_W;
   endfunction

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_ONCE   = 2'd1,
      MODE_AUTO   = 2'd2,
      MODE_BOTH   = 2'd3
   } send_mode_e;
endpackage

// File: rtl/sts_ctrl.sv
module sts_ctrl #(
   parameter int PAYLOAD_W = 18
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_i,
   input  logic [7:0]                 byte_i,
   input  logic [PAYLOAD_W-1:0]       status_i,
   output logic [sts_pkg::SEQ_W-1:0]  seq_o,
   output logic                       trig_o
);
   import sts_pkg::*;

   send_mode_e             mode_q;
   logic [SEQ_W-1:0]       seq_q;
   logic [PAYLOAD_W-1:0]   prev_q;
   logic                   changed_w;
   logic                   auto_w;

   assign changed_w = (status_i != prev_q);
   assign auto_w    = (mode_q == MODE_AUTO) || (mode_q == MODE_BOTH);
   assign trig_o    = (wr_i && byte_i[0]) || (auto_w && changed_w);
   assign seq_o     = seq_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mode_q <= MODE_IDLE;
         seq_q  <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= status_i;
         if (wr_i) begin
            seq_q  <= byte_i[7:2];
            mode_q <= send_mode_e'(byte_i[1:0]);
         end
      end
   end

   // R8
   seq_load_chk: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> (seq_o == $past(byte_i[7:2])));
endmodule

// File: rtl/sts_hs.sv
module sts_hs (
   input  logic clk,
   input  logic rst,
   input  logic trig_i,
   input  logic ack_i,
   input  logic free_i,
   output logic req_o,
   output logic accept_o
);
   logic req_q;
   logic pend_q;
   logic launch_w;

   assign accept_o = req_q && ack_i;
   assign launch_w = !req_q && free_i && (trig_i || pend_q);
   assign req_o    = req_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (req_q) req_q <= !ack_i;
         else       req_q <= launch_w;

         if (launch_w)
            pend_q <= 1'b0;
         else if (trig_i && !(req_q && !ack_i))
            pend_q <= 1'b1;
      end
   end

   // R2
   req_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (req_o && ack_i) |=> !req_o);
   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req_o && !ack_i) |=> req_o);
endmodule

// File: rtl/sts_serializer.sv
module sts_serializer #(
   parameter int PAYLOAD_W = 18
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       accept_i,
   input  logic [sts_pkg::SEQ_W-1:0]  seq_i,
   input  logic [PAYLOAD_W-1:0]       status_i,
   output logic                       busy_o,
   output logic [7:0]                 data_o
);
   localparam int NPAY  = sts_pkg::pay_bytes(PAYLOAD_W);
   localparam int SH_W  = NPAY * 8;
   localparam int PAD_W = SH_W - (PAYLOAD_W - 2);
   localparam int CNT_W = $clog2(NPAY + 2);
   localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(NPAY + 1);

   logic [SH_W-1:0]  load_w;
   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       data_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign load_w = {{PAD_W{1'b0}}, status_i[PAYLOAD_W-1:2]};
      end else begin : g_exact
         assign load_w = status_i[PAYLOAD_W-1:2];
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         data_q <= '0;
      end else if (accept_i) begin
         data_q <= {seq_i, status_i[1:0]};
         sh_q   <= load_w;
         cnt_q  <= LOAD_CNT;
      end else if (cnt_q != '0) begin
         data_q <= (cnt_q > CNT_W'(1)) ? sh_q[7:0] : 8'h00;
         sh_q   <= sh_q >> 8;
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign busy_o = (cnt_q != '0);
   assign data_o = data_q;

   // R4
   seq_byte_chk: assert property (@(posedge clk) disable iff (rst)
      accept_i |=> (data_o == {$past(seq_i), $past(status_i[1:0])}));
endmodule

// File: rtl/status_packet_gen.sv
module status_packet_gen #(
   parameter logic [7:0] ADDR_BYTE = 8'h3B,
   parameter int         PAYLOAD_W = 18
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ctl_wr,
   input  logic [7:0]           ctl_byte,
   input  logic [PAYLOAD_W-1:0] status_in,
   input  logic                 pkt_ack,
   output logic                 pkt_req,
   output logic [7:0]           pkt_byte
);
   generate
      if (PAYLOAD_W < 3 || PAYLOAD_W > 26) begin : g_bad_width
         $error("PAYLOAD_W must lie in 3..26");
      end
   endgenerate

   logic [sts_pkg::SEQ_W-1:0] seq_w;
   logic                      trig_w;
   logic                      accept_w;
   logic                      busy_w;
   logic [7:0]                data_w;

   sts_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_ctrl (
      .clk(clk), .rst(rst), .wr_i(ctl_wr), .byte_i(ctl_byte),
      .status_i(status_in), .seq_o(seq_w), .trig_o(trig_w));

   sts_hs u_hs (
      .clk(clk), .rst(rst), .trig_i(trig_w), .ack_i(pkt_ack),
      .free_i(!busy_w), .req_o(pkt_req), .accept_o(accept_w));

   sts_serializer #(.PAYLOAD_W(PAYLOAD_W)) u_ser (
      .clk(clk), .rst(rst), .accept_i(accept_w), .seq_i(seq_w),
      .status_i(status_in), .busy_o(busy_w), .data_o(data_w));

   assign pkt_byte = pkt_req ? ADDR_BYTE : data_w;

   // R11
   req_idle_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_req |-> !busy_w);
   // R7
   quiet_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!pkt_req && !busy_w) |-> (pkt_byte == 8'h00));
endmodule

// File: tb/status_packet_gen_test.sv
module status_packet_gen_test;
   localparam int         CLK_P = 10;
   localparam int         PW    = 18;
   localparam int         NPAY  = 2;
   localparam logic [7:0] ADDR  = 8'h3B;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_byte = 8'h00;
   logic [PW-1:0] status = '0;
   logic          pkt_ack = 1'b0;
   logic          pkt_req;
   logic [7:0]    pkt_byte;

   int checks = 0;
   int errors = 0;

   status_packet_gen uut (
      .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
      .status_in(status), .pkt_ack(pkt_ack), .pkt_req(pkt_req),
      .pkt_byte(pkt_byte));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [7:0] b);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_byte = b;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tag, pkt_req, 0);
      end
   endtask

   // caller stands at a negedge with pkt_req high
   task automatic take_packet(input logic [5:0] seq, input bit chg,
                              input logic [PW-1:0] st_next,
                              input bit coll, input logic [7:0] cb);
      logic [PW-1:0] st;
      st = status;
      chk("R3 address byte", pkt_byte, ADDR);
      pkt_ack = 1'b1;
      if (coll) begin ctl_wr = 1'b1; ctl_byte = cb; end
      @(negedge clk);
      pkt_ack = 1'b0; ctl_wr = 1'b0;
      chk("R2 req drops after ack", pkt_req, 0);
      chk("R4 seq byte", pkt_byte, {seq, st[1:0]});
      if (chg) status = st_next;
      for (int k = 0; k < NPAY; k++) begin
         @(negedge clk);
         chk(chg ? "R6 latched payload" : "R5 payload byte",
             pkt_byte, int'((32'(st) >> (2 + 8*k)) & 32'hFF));
      end
      @(negedge clk);
      chk("R7 zero after packet", pkt_byte, 0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 req after reset", pkt_req, 0);
      chk("R1 byte after reset", pkt_byte, 0);
      rst = 1'b0;
      quiet("R1 idle after reset", 2);
   endtask

   task automatic t_single();
      status = 18'h2A5C3;
      @(negedge clk);
      ctl_write({6'd5, 2'b01});
      chk("R8 single-send request", pkt_req, 1);
      take_packet(6'd5, 1'b1, 18'h15A3C, 1'b0, 8'h00);
      status = 18'h00F0F;
      quiet("R9 change ignored in mode 1", 4);
      chk("R7 idle byte zero", pkt_byte, 0);
   endtask

   task automatic t_auto();
      ctl_write({6'd9, 2'b10});
      chk("R8 mode 2 write sends nothing", pkt_req, 0);
      quiet("R8 mode 2 quiet", 2);
      status = 18'h3FFFE;
      @(negedge clk);
      chk("R9 auto request on change", pkt_req, 1);
      take_packet(6'd9, 1'b0, '0, 1'b0, 8'h00);
      quiet("R9 no repeat without change", 3);
   endtask

   task automatic t_merge();
      status = 18'h12345;
      @(negedge clk);
      chk("R9 auto request", pkt_req, 1);
      status = 18'h0ABCD;
      @(negedge clk);
      chk("R2 req holds without ack", pkt_req, 1);
      status = 18'h2F00D;
      @(negedge clk);
      take_packet(6'd9, 1'b0, '0, 1'b0, 8'h00);
      quiet("R10 merged triggers add nothing", 5);
   endtask

   task automatic t_collide();
      status = 18'h31337;
      @(negedge clk);
      chk("R9 auto request", pkt_req, 1);
      take_packet(6'd9, 1'b0, '0, 1'b1, {6'd12, 2'b11});
      @(negedge clk);
      chk("R11 follow-up request", pkt_req, 1);
      take_packet(6'd12, 1'b0, '0, 1'b0, 8'h00);
      quiet("R11 exactly one follow-up", 5);
   endtask

   task automatic t_idle_mode();
      ctl_write({6'd33, 2'b00});
      chk("R8 mode 0 write sends nothing", pkt_req, 0);
      status = 18'h00001;
      quiet("R9 change ignored in mode 0", 4);
      chk("R7 idle byte zero", pkt_byte, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      t_auto();
      t_merge();
      t_collide();
      t_idle_mode();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule